// File: doc/BRIEF.md
# Dual-Buffer Frame Receiver with Destination Filter

This block is the receive half of a small memory-mapped Ethernet controller. Frame octets arrive one per cycle on a valid/last stream with no backpressure. The first six octets are the destination address. They are held aside until the sixth one arrives, and at that point the block decides whether the frame belongs to this station. Only frames it keeps are written into storage.

Two equal frame buffers sit behind a 32-bit register bus. Each buffer ends in a control word that holds a full flag and an interrupt-enable flag. When a kept frame completes, its buffer is marked full. A one-cycle interrupt may then be raised, and in alternating mode the next frame goes to the other buffer. Software reads the frame out of its buffer and clears the full flag to give the buffer back. If a frame meets a full buffer, it is lost and a one-cycle pulse reports the loss.

Top module: `rxf_pingpong_rx`

## Requirements
- R1: After reset the current buffer is buffer 0, both control words read 0, and `irq` and `frame_lost` are low.
- R2: A frame of six or more octets is kept when bit 7 of its first octet is set, or when its octet k (k = 0..5) equals `station_mac[47-8k -: 8]` for every k.
- R3: A frame that fails the filter is not stored, leaves both control words unchanged and raises neither `irq` nor `frame_lost`.
- R4: Frame octet n lands in word n/4, bits [8*(n%4)+7 : 8*(n%4)], of its buffer. The most significant bit of `bus_addr` selects the buffer. The last word of each buffer (word BUF_BYTES/4-1) is its control word, with bit 0 as the full flag and bit 3 as the interrupt enable. Bus reads are combinational.
- R5: When the last octet of a kept frame is taken, the full flag of the frame's buffer reads 1 from the next cycle on.
- R6: A frame that passes the filter while the current buffer is full is not stored, and `frame_lost` is high for exactly the one cycle after its sixth octet.
- R7: Frames shorter than six octets are ignored. A kept frame longer than BUF_BYTES-4 octets is abandoned: its full flag stays clear, no interrupt is raised and the current buffer does not change. A frame of exactly BUF_BYTES-4 octets is kept.
- R8: `irq` is high for one cycle, the cycle after a frame completes, if and only if buffer 0's interrupt enable and `irq_global_en` are set. This holds whichever buffer took the frame.
- R9: With `pingpong_en` high, each completed frame switches the current buffer. With it low, every frame goes to buffer 0.
- R10: A bus write to a control word loads the full flag from data bit 0 and the interrupt enable from data bit 3. Writing bit 0 as 0 releases the buffer.
- R11: When a bus write to a control word and the completion of a frame into that buffer fall in the same cycle, the full flag ends up set. The interrupt decision uses the interrupt enable held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pingpong_en | input | 1 | Alternate between the two buffers |
| irq_global_en | input | 1 | Global interrupt enable |
| station_mac | input | 48 | Station address; bits 47:40 are the first octet |
| rx_valid | input | 1 | Octet on `rx_data` is valid |
| rx_data | input | 8 | Frame octet |
| rx_last | input | 1 | Last octet of the frame |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write when high |
| bus_addr | input | ADDR_W (5) | Word address: buffer bit, then word index |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data |
| irq | output | 1 | Receive interrupt pulse |
| frame_lost | output | 1 | Frame dropped because its buffer was full |

## Verification
A software write to a control word and a hardware frame completion into the same buffer can land in the same clock cycle. That write can clear the full flag, change the interrupt enable, or both. The bench provokes this by driving the bus write during the exact cycle that carries the last octet. It includes frames of exactly six octets, where the filter decision, the header flush and the completion all happen in that one cycle. The result is judged against the rule that the hardware set of the full flag wins and the interrupt uses the old enable: the bench reads the control word afterwards and counts interrupt pulses.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned HDR_BYTES = 6;

  typedef enum logic [1:0] {
    ST_HDR   = 2'd0,
    ST_STORE = 2'd1,
    ST_SKIP  = 2'd2
  } rxf_state_e;
endpackage

// File: rtl/rxf_dst_filter.sv
module rxf_dst_filter #(
  parameter int unsigned HDR_BYTES = 6,
  localparam int unsigned IDX_W = $clog2(HDR_BYTES)
) (
  input  logic                   clk,
  input  logic                   cap_en,
  input  logic [IDX_W-1:0]       cap_idx,
  input  logic [7:0]             byte_in,
  input  logic [8*HDR_BYTES-1:0] station_mac,
  output logic [8*HDR_BYTES-1:0] frame_hdr,
  output logic                   hit
);
  logic [7:0]           hdr_q [HDR_BYTES-1];
  logic [HDR_BYTES-1:0] eq;

  for (genvar k = 0; k < HDR_BYTES - 1; k++) begin : g_cap
    always_ff @(posedge clk) begin
      if (cap_en && (cap_idx == IDX_W'(k))) hdr_q[k] <= byte_in;
    end
    assign frame_hdr[8*k +: 8] = hdr_q[k];
  end
  assign frame_hdr[8*(HDR_BYTES-1) +: 8] = byte_in;

  for (genvar k = 0; k < HDR_BYTES; k++) begin : g_cmp
    assign eq[k] = (frame_hdr[8*k +: 8] == station_mac[8*(HDR_BYTES-1-k) +: 8]);
  end

  assign hit = frame_hdr[7] | (&eq);
endmodule

// File: rtl/rxf_frame_mem.sv
module rxf_frame_mem #(
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned HDR_BYTES = 6,
  localparam int unsigned IW  = $clog2(BUF_BYTES),
  localparam int unsigned WAW = IW - 2
) (
  input  logic                   clk,
  input  logic                   hdr_we,
  input  logic                   hdr_buf,
  input  logic [8*HDR_BYTES-1:0] hdr_data,
  input  logic                   byte_we,
  input  logic                   byte_buf,
  input  logic [IW-1:0]          byte_idx,
  input  logic [7:0]             byte_data,
  input  logic                   rd_buf,
  input  logic [WAW-1:0]         rd_word,
  output logic [31:0]            rd_data
);
  logic [7:0] mem_q [2][BUF_BYTES];

  for (genvar b = 0; b < 2; b++) begin : g_buf
    for (genvar n = 0; n < BUF_BYTES; n++) begin : g_byte
      logic hdr_hit;
      logic byte_hit;
      if (n < HDR_BYTES) begin : g_h
        assign hdr_hit = hdr_we && (hdr_buf == 1'(b));
      end else begin : g_nh
        assign hdr_hit = 1'b0;
      end
      assign byte_hit = byte_we && (byte_buf == 1'(b)) && (byte_idx == IW'(n));
      always_ff @(posedge clk) begin
        if (hdr_hit) begin
          mem_q[b][n] <= hdr_data[8*(n % HDR_BYTES) +: 8];
        end else if (byte_hit) begin
          mem_q[b][n] <= byte_data;
        end
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_rd
    assign rd_data[8*k +: 8] = mem_q[rd_buf][{rd_word, 2'(k)}];
  end
endmodule

// File: rtl/rxf_pingpong_rx.sv
module rxf_pingpong_rx
  import rxf_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 64,
  localparam int unsigned WORDS      = BUF_BYTES / 4,
  localparam int unsigned WAW        = $clog2(WORDS),
  localparam int unsigned ADDR_W     = WAW + 1,
  localparam int unsigned CNT_W      = $clog2(BUF_BYTES),
  localparam int unsigned DATA_BYTES = BUF_BYTES - 4,
  localparam int unsigned IDX_W      = $clog2(HDR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pingpong_en,
  input  logic              irq_global_en,
  input  logic [47:0]       station_mac,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              frame_lost
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rxf_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cur_q, cur_n;
  logic             frm_buf_q, frm_buf_n;
  logic [1:0]       s_q, s_n, i_q, i_n;
  logic             irq_q, irq_n, lost_q, lost_n;

  logic             sel_buf, hit, hdr_cap, flush, byte_we, commit, commit_buf;
  logic [1:0]       wr_ctrl;
  logic [8*HDR_BYTES-1:0] frame_hdr;
  logic [31:0]      mem_rd;
  logic             unused_wdata;

  assign unused_wdata = ^{bus_wdata[31:4], bus_wdata[2:1]};
  assign sel_buf      = cur_q & pingpong_en;

  rxf_dst_filter #(.HDR_BYTES(HDR_BYTES)) u_filter (
    .clk        (clk),
    .cap_en     (hdr_cap),
    .cap_idx    (cnt_q[IDX_W-1:0]),
    .byte_in    (rx_data),
    .station_mac(station_mac),
    .frame_hdr  (frame_hdr),
    .hit        (hit)
  );

  rxf_frame_mem #(.BUF_BYTES(BUF_BYTES), .HDR_BYTES(HDR_BYTES)) u_mem (
    .clk      (clk),
    .hdr_we   (flush),
    .hdr_buf  (sel_buf),
    .hdr_data (frame_hdr),
    .byte_we  (byte_we),
    .byte_buf (frm_buf_q),
    .byte_idx (cnt_q),
    .byte_data(rx_data),
    .rd_buf   (bus_addr[ADDR_W-1]),
    .rd_word  (bus_addr[WAW-1:0]),
    .rd_data  (mem_rd)
  );

  // frame sequencing
  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    frm_buf_n = frm_buf_q;
    hdr_cap   = 1'b0;
    flush     = 1'b0;
    byte_we   = 1'b0;
    commit    = 1'b0;
    lost_n    = 1'b0;
    unique case (state_q)
      ST_HDR: if (rx_valid) begin
        cnt_n = '0;
        if (cnt_q == CNT_W'(HDR_BYTES - 1)) begin
          state_n = rx_last ? ST_HDR : ST_SKIP;
          if (hit && s_q[sel_buf]) begin
            lost_n = 1'b1;
          end else if (hit) begin
            flush     = 1'b1;
            frm_buf_n = sel_buf;
            if (rx_last) begin
              commit = 1'b1;
            end else begin
              state_n = ST_STORE;
              cnt_n   = CNT_W'(HDR_BYTES);
            end
          end
        end else begin
          hdr_cap = 1'b1;
          if (!rx_last) cnt_n = cnt_q + 1'b1;
        end
      end
      ST_STORE: if (rx_valid) begin
        if (cnt_q == CNT_W'(DATA_BYTES)) begin
          state_n = rx_last ? ST_HDR : ST_SKIP;
          cnt_n   = '0;
        end else begin
          byte_we = 1'b1;
          if (rx_last) begin
            commit  = 1'b1;
            state_n = ST_HDR;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_SKIP: if (rx_valid && rx_last) begin
        state_n = ST_HDR;
        cnt_n   = '0;
      end
      default: state_n = ST_HDR;
    endcase
  end

  // control words, buffer index, interrupt
  assign commit_buf = (state_q == ST_HDR) ? sel_buf : frm_buf_q;

  for (genvar b = 0; b < 2; b++) begin : g_ctrl
    assign wr_ctrl[b] = bus_sel && bus_we && (bus_addr[ADDR_W-1] == 1'(b)) &&
                        (bus_addr[WAW-1:0] == WAW'(WORDS - 1));
    assign s_n[b] = (wr_ctrl[b] ? bus_wdata[0] : s_q[b]) |
                    (commit && (commit_buf == 1'(b)));
    assign i_n[b] = wr_ctrl[b] ? bus_wdata[3] : i_q[b];
  end

  assign cur_n = commit ? (pingpong_en & ~commit_buf) : cur_q;
  assign irq_n = commit && i_q[0] && irq_global_en;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= ST_HDR;
      cnt_q     <= '0;
      cur_q     <= 1'b0;
      frm_buf_q <= 1'b0;
      s_q       <= '0;
      i_q       <= '0;
      irq_q     <= 1'b0;
      lost_q    <= 1'b0;
    end else begin
      if (rx_valid) begin
        state_q   <= state_n;
        cnt_q     <= cnt_n;
        frm_buf_q <= frm_buf_n;
      end
      if (commit) cur_q <= cur_n;
      if (commit || (|wr_ctrl)) begin
        s_q <= s_n;
        i_q <= i_n;
      end
      irq_q  <= irq_n;
      lost_q <= lost_n;
    end
  end

  assign irq        = irq_q;
  assign frame_lost = lost_q;
  assign bus_rdata  = (bus_addr[WAW-1:0] == WAW'(WORDS - 1)) ?
                      {28'd0, i_q[bus_addr[ADDR_W-1]], 2'b00, s_q[bus_addr[ADDR_W-1]]} :
                      mem_rd;
endmodule

// File: rtl/rxf_pingpong_rx_chk.sv
module rxf_pingpong_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       frame_lost,
  input logic       irq_global_en,
  input logic       pingpong_en,
  input logic [1:0] s_q,
  input logic       cur_q,
  input logic [1:0] wr_ctrl
);
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_global_en));

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (s_q != 2'b00));

  p_lost_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lost |-> $past(s_q[cur_q & pingpong_en]));

  p_idx_pp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur_q) |-> $past(pingpong_en));

  p_full_hold0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(s_q[0]) && !$past(wr_ctrl[0])) |-> s_q[0]);

  p_full_hold1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(s_q[1]) && !$past(wr_ctrl[1])) |-> s_q[1]);
endmodule

bind rxf_pingpong_rx rxf_pingpong_rx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .irq          (irq),
  .frame_lost   (frame_lost),
  .irq_global_en(irq_global_en),
  .pingpong_en  (pingpong_en),
  .s_q          (s_q),
  .cur_q        (cur_q),
  .wr_ctrl      (wr_ctrl)
);

// File: tb/tb_rxf_pingpong_rx.sv
module tb_rxf_pingpong_rx;
  localparam int BB   = 64;
  localparam int MAXD = BB - 4;
  localparam logic [47:0] MAC = 48'h02_1A_3C_55_7E_91;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pingpong_en, irq_global_en;
  logic        rx_valid, rx_last;
  logic [7:0]  rx_data;
  logic        bus_sel, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, frame_lost;

  always #4 clk = ~clk;

  rxf_pingpong_rx dut (
    .clk(clk), .rst_n(rst_n), .pingpong_en(pingpong_en), .irq_global_en(irq_global_en),
    .station_mac(MAC), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .frame_lost(frame_lost)
  );

  int n_tests = 0, n_fail = 0;
  int irq_cnt = 0, lost_cnt = 0, exp_irq = 0, exp_lost = 0;
  logic [7:0] fb [128];
  logic [7:0] m_mem [2][BB];
  logic [1:0] m_s, m_i;
  logic       m_cur;
  int         m_len [2];

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (frame_lost) lost_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] ctrl_addr(input logic b);
    return {b, 4'hF};
  endfunction

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  // build frame in fb: kind 0 = station match, 1 = group bit, 2 = near miss
  task automatic build(input int kind, input int len);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    if (kind != 1) for (int k = 0; k < 6; k++) fb[k] = MAC[8*(5-k) +: 8];
    if (kind == 1) fb[0] = fb[0] | 8'h80;
    if (kind == 2) fb[$urandom_range(0, 5)] ^= 8'h01;
  endtask

  function automatic bit accepted(input int len);
    bit eq = 1'b1;
    for (int k = 0; k < 6; k++) if (fb[k] != MAC[8*(5-k) +: 8]) eq = 1'b0;
    return (len >= 6) && (fb[0][7] || eq);
  endfunction

  // reference model; returns buffer index committed, or -1
  function automatic int model(input int len, input bit cw, input logic [31:0] cv, input bit cb);
    int  res = -1;
    logic sel = m_cur & pingpong_en;
    if (accepted(len)) begin
      if (m_s[sel]) exp_lost++;
      else begin
        for (int n = 0; n < len && n < MAXD; n++) m_mem[sel][n] = fb[n];
        if (len <= MAXD) begin
          res = int'(sel);
          m_len[sel] = len;
          if (m_i[0] && irq_global_en) exp_irq++;
          m_cur = pingpong_en & ~sel;
        end
      end
    end
    if (cw) begin
      m_s[cb] = cv[0] | (res == int'(cb));
      m_i[cb] = cv[3];
    end
    if (res >= 0) m_s[res] = 1'b1;
    return res;
  endfunction

  task automatic send(input int len, input bit cw, input logic [31:0] cv, input bit cb);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fb[i]; rx_last = (i == len - 1);
      if (cw && i == len - 1) begin
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ctrl_addr(cb); bus_wdata = cv;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_ctrl(input string tag);
    logic [31:0] d;
    for (int b = 0; b < 2; b++) begin
      bus_read(ctrl_addr(1'(b)), d);
      chk(tag, d, {28'd0, m_i[b], 2'b00, m_s[b]});
    end
  endtask

  task automatic check_data(input int b);
    logic [31:0] d;
    for (int w = 0; w < (m_len[b] + 3) / 4; w++) begin
      bus_read({1'(b), 4'(w)}, d);
      for (int k = 0; k < 4; k++)
        if (4 * w + k < m_len[b]) chk("R4 data", {24'd0, d[8*k +: 8]}, {24'd0, m_mem[b][4*w+k]});
    end
  endtask

  task automatic frame(input int kind, input int len, input bit cw, input logic [31:0] cv,
                       input bit cb, input string tag);
    int r;
    build(kind, len);
    r = model(len, cw, cv, cb);
    send(len, cw, cv, cb);
    check_ctrl(tag);
    chk("R8 irq count", irq_cnt, exp_irq);
    chk("R6 lost count", lost_cnt, exp_lost);
    if (r >= 0) check_data(r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd7321));
    rst_n = 1'b0; pingpong_en = 1'b1; irq_global_en = 1'b1;
    rx_valid = 1'b0; rx_last = 1'b0; rx_data = '0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_s = '0; m_i = '0; m_cur = 1'b0; m_len[0] = 0; m_len[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_ctrl("R1 reset ctrl");
    chk("R1 irq low", irq, 0);
    chk("R1 lost low", frame_lost, 0);

    // R10 write sets and releases
    bus_write(ctrl_addr(1'b0), 32'h9); m_s[0] = 1'b1; m_i[0] = 1'b1;
    check_ctrl("R10 set");
    bus_write(ctrl_addr(1'b0), 32'h8); m_s[0] = 1'b0;
    check_ctrl("R10 release");

    // R2 station match into buffer 0, then group bit into buffer 1
    frame(0, 20, 0, 0, 0, "R2 match");
    frame(1, 9, 0, 0, 0, "R2 group");
    // R6 both full: lost
    frame(1, 12, 0, 0, 0, "R6 full");
    // R3 near miss: ignored even after release
    bus_write(ctrl_addr(1'b0), 32'h8); m_s[0] = 1'b0;
    frame(2, 14, 0, 0, 0, "R3 reject");
    // R7 short and too long, then exactly max
    frame(1, 5, 0, 0, 0, "R7 short");
    frame(0, MAXD + 1, 0, 0, 0, "R7 long");
    frame(0, MAXD, 0, 0, 0, "R7 max");
    // R9 ping-pong off: stays on buffer 0
    pingpong_en = 1'b0;
    bus_write(ctrl_addr(1'b0), 32'h8); m_s[0] = 1'b0;
    bus_write(ctrl_addr(1'b1), 32'h0); m_s[1] = 1'b0;
    frame(0, 8, 0, 0, 0, "R9 pp off");
    bus_write(ctrl_addr(1'b0), 32'h8); m_s[0] = 1'b0;
    frame(1, 8, 0, 0, 0, "R9 pp off again");
    bus_read(ctrl_addr(1'b1), d);
    chk("R9 buffer 1 untouched", d[0], 0);
    // R11 same-cycle release write and completion; enable flip uses old value
    bus_write(ctrl_addr(1'b0), 32'h0); m_s[0] = 1'b0; m_i[0] = 1'b0;
    frame(0, 6, 1, 32'h8, 0, "R11 commit wins");
    bus_read(ctrl_addr(1'b0), d);
    chk("R11 full set", d[0], 1);
    bus_write(ctrl_addr(1'b0), 32'h8); m_s[0] = 1'b0;
    frame(1, 11, 1, 32'h0, 0, "R11 old enable");

    // random traffic
    for (int it = 0; it < 300; it++) begin
      pingpong_en   = ($urandom_range(0, 3) != 0);
      irq_global_en = ($urandom_range(0, 3) != 0);
      for (int b = 0; b < 2; b++) if (m_s[b] && $urandom_range(0, 1)) begin
        logic en = (b == 0) ? 1'($urandom_range(0, 1)) : 1'b0;
        bus_write(ctrl_addr(1'(b)), {28'd0, en, 3'b000});
        m_s[b] = 1'b0; m_i[b] = en;
      end
      frame($urandom_range(0, 2), $urandom_range(1, MAXD + 4),
            ($urandom_range(0, 7) == 0), {28'd0, 1'($urandom), 3'd0}, 1'($urandom),
            "R5 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule